// File: doc/BRIEF.md
# Ternary Logic Gate Unit

This is a combinational unit that applies one selected three-valued operation to one or two trits. A trit travels on two wires: `00` means 0, `01` means 1, `10` means 2, and `11` is not a legal value. A 4-bit opcode selects the operation. The unit offers three kinds of single-operand inverter, the two cycling gates, identity, three constants, min/max-based dyadic gates, and a buffer that turns a two-valued trit (0 or 2) into 0 or 1.

A separate three-line output always decodes operand A. Each line is a binary stand-in for a trit that is either 2 (line high) or 0 (line low). An error flag reports an illegal code on an operand that the selected operation reads.

Top module: `tlu_core`

## Requirements
- R1: The trit code is 00=0, 01=1, 10=2. Operand code 11 is illegal. The flag `err_o` rises when A is 11 under opcodes 0..13, or when B is 11 under opcodes 9..12. While `err_o` is high, `res_o` is 00. `res_o` never carries 11.
- R2: Opcode 0 is the standard inverter: 0→2, 1→1, 2→0.
- R3: Opcode 1 is the negative-threshold inverter: 0→2, 1→0, 2→0.
- R4: Opcode 2 is the positive-threshold inverter: 0→2, 1→2, 2→0.
- R5: Opcode 3 gives A+1 mod 3. Opcode 4 gives A−1 mod 3.
- R6: For every legal A, decrement equals two successive increments. It also equals standard invert, then increment, then standard invert.
- R7: Opcode 5 returns A unchanged. Opcodes 6, 7 and 8 return the constants 0, 1 and 2.
- R8: Opcode 9 returns the standard inversion of min(A,B). Opcode 10 returns the standard inversion of max(A,B).
- R9: Opcode 11 returns min(A,B). Opcode 12 returns max(A,B).
- R10: `dec_o[k]` is 1 exactly when A equals k, for k in 0..2. All lines are 0 when A is 11.
- R11: Opcode 13 is the buffer: 0→0, 2→1, and 1→2 (the cascaded decrement-then-invert result).
- R12: Opcodes 14 and 15 return 00 and never raise `err_o`, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation select |
| a_i | input | 2 | Operand A trit |
| b_i | input | 2 | Operand B trit (dyadic operations only) |
| res_o | output | 2 | Result trit |
| err_o | output | 1 | Illegal operand code seen |
| dec_o | output | 3 | Decoder lines for A, bit k high when A equals k |

## Verification
The bench walks every opcode against every pair of operand codes. This covers the middle value 1, where the three inverters differ. A unit that swapped the negative and positive threshold variants would fail at A=1 under opcodes 1 and 2. The bench also drives the buffer with the unspecified input 1. A design that left 1 unchanged, or that cleared it, would show 1 or 0 there instead of 2.

The bench chains the unit's own increment and invert results to prove both decrement identities. A wrap error in either cycling gate breaks them. For illegal codes, the bench checks that B is ignored by single-operand operations. It also checks that the unused opcodes stay quiet. A design that flagged every 11 regardless of opcode would raise `err_o` wrongly in those cases.

// File: rtl/tlu_core.sv
module tlu_core #(
  parameter int OPW = 4
) (
  input  logic [OPW-1:0] op_i,
  input  logic [1:0]     a_i,
  input  logic [1:0]     b_i,
  output logic [1:0]     res_o,
  output logic           err_o,
  output logic [2:0]     dec_o
);

  localparam logic [1:0] T0 = 2'b00, T1 = 2'b01, T2 = 2'b10;

  function automatic logic [1:0] t_inv(input logic [1:0] x);
    return (x == T0) ? T2 : (x == T2) ? T0 : x;
  endfunction

  function automatic logic [1:0] t_inc(input logic [1:0] x);
    return (x == T0) ? T1 : (x == T1) ? T2 : T0;
  endfunction

  logic [1:0] lo, hi, dn;
  logic       a_bad, b_bad, dyadic, used;

  assign a_bad  = (a_i == 2'b11);
  assign b_bad  = (b_i == 2'b11);
  assign lo     = (a_i < b_i) ? a_i : b_i;
  assign hi     = (a_i < b_i) ? b_i : a_i;
  assign dn     = t_inc(t_inc(a_i));
  assign dyadic = (op_i >= OPW'(9)) && (op_i <= OPW'(12));
  assign used   = (op_i <= OPW'(13));
  assign err_o  = used && (a_bad || (dyadic && b_bad));

  genvar k;
  generate
    for (k = 0; k < 3; k++) begin : g_dec
      assign dec_o[k] = (a_i == 2'(k));
    end
  endgenerate

  always_comb begin
    res_o = T0;
    if (!err_o) begin
      case (op_i)
        OPW'(0):  res_o = t_inv(a_i);
        OPW'(1):  res_o = (a_i == T0) ? T2 : T0;
        OPW'(2):  res_o = (a_i == T2) ? T0 : T2;
        OPW'(3):  res_o = t_inc(a_i);
        OPW'(4):  res_o = dn;
        OPW'(5):  res_o = a_i;
        OPW'(6):  res_o = T0;
        OPW'(7):  res_o = T1;
        OPW'(8):  res_o = T2;
        OPW'(9):  res_o = t_inv(lo);
        OPW'(10): res_o = t_inv(hi);
        OPW'(11): res_o = t_inv(t_inv(lo));
        OPW'(12): res_o = t_inv(t_inv(hi));
        OPW'(13): res_o = t_inv(dn);
        default:  res_o = T0;
      endcase
    end
  end

endmodule

module tlu_core_chk (
  input logic [3:0] op_i,
  input logic [1:0] a_i,
  input logic [1:0] b_i,
  input logic [1:0] res_o,
  input logic       err_o,
  input logic [2:0] dec_o
);

  always_comb begin
    AST_ERR_ZERO: assert final (!err_o || res_o == 2'b00);
    AST_RES_LEGAL: assert final (res_o != 2'b11);
    AST_DEC_ONEHOT: assert final ($onehot0(dec_o));
    AST_DEC_ILLEGAL: assert final ((a_i == 2'b11) == (dec_o == 3'b000));
    AST_UNUSED_QUIET: assert final (op_i < 4'd14 || (!err_o && res_o == 2'b00));
    AST_NAND_ZERO: assert final (!(op_i == 4'd9 && !err_o && (a_i == 2'b00 || b_i == 2'b00)) || res_o == 2'b10);
    AST_OR_TOP: assert final (!(op_i == 4'd12 && !err_o && (a_i == 2'b10 || b_i == 2'b10)) || res_o == 2'b10);
  end

  // AST_ERR_ZERO R1, AST_RES_LEGAL R1, AST_DEC_ONEHOT R10, AST_DEC_ILLEGAL R10,
  // AST_UNUSED_QUIET R12, AST_NAND_ZERO R8, AST_OR_TOP R9

endmodule

bind tlu_core tlu_core_chk u_chk (.*);

// File: tb/tb_tlu_core.sv
module tb_tlu_core;

  logic       clk = 1'b0;
  logic [3:0] op;
  logic [1:0] a, b;
  logic [1:0] res;
  logic       err;
  logic [2:0] dec;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tlu_core dut (.op_i(op), .a_i(a), .b_i(b), .res_o(res), .err_o(err), .dec_o(dec));

  function automatic int mod3(input int v);
    return ((v % 3) + 3) % 3;
  endfunction

  function automatic int exp_res(input int o, input int x, input int y);
    int mn, mx;
    mn = (x < y) ? x : y;
    mx = (x > y) ? x : y;
    case (o)
      0: return 2 - x;
      1: return (x == 0) ? 2 : 0;
      2: return (x == 2) ? 0 : 2;
      3: return mod3(x + 1);
      4: return mod3(x - 1);
      5: return x;
      6: return 0;
      7: return 1;
      8: return 2;
      9: return 2 - mn;
      10: return 2 - mx;
      11: return mn;
      12: return mx;
      13: return (x == 2) ? 1 : (x == 1) ? 2 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_err(input int o, input int x, input int y);
    if (o > 13) return 1'b0;
    if (x == 3) return 1'b1;
    return (o >= 9 && o <= 12 && y == 3);
  endfunction

  function automatic string tag(input int o);
    case (o)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5, 6, 7, 8: return "R7";
      9, 10: return "R8";
      11, 12: return "R9";
      13: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0d expected=%0d", req, op, a, b, act, exp);
    end
  endtask

  task automatic apply(input int o, input int x, input int y);
    int ee;
    op = 4'(o); a = 2'(x); b = 2'(y);
    #2;
    ee = exp_err(o, x, y);
    check(ee ? "R1" : tag(o), int'(res), ee ? 0 : exp_res(o, x, y));
    check(((o >= 14) ? "R12" : "R1"), int'(err), ee);
    check("R10", int'(dec), (x == 3) ? 0 : (1 << x));
  endtask

  task automatic eval1(input int o, input int x, output int r);
    op = 4'(o); a = 2'(x); b = 2'b00;
    #2;
    r = int'(res);
  endtask

  initial begin
    int s, t, u, d;
    void'($urandom(32'd7331));
    op = 4'd0; a = 2'd0; b = 2'd0;
    #2;
    check("R2", int'(res), 2);
    check("R1", int'(err), 0);
    check("R10", int'(dec), 1);
    for (int o = 0; o < 16; o++)
      for (int x = 0; x < 4; x++)
        for (int y = 0; y < 4; y++)
          apply(o, x, y);
    for (int x = 0; x < 3; x++) begin
      eval1(4, x, d);
      eval1(3, x, s);
      eval1(3, s, t);
      check("R6", t, d);
      eval1(0, x, s);
      eval1(3, s, t);
      eval1(0, t, u);
      check("R6", u, d);
    end
    apply(13, 1, 3);
    apply(0, 1, 3);
    apply(14, 3, 3);
    apply(15, 3, 3);
    for (int i = 0; i < 2000; i++)
      apply(int'($urandom_range(15)), int'($urandom_range(3)), int'($urandom_range(3)));
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule